// File: doc/BRIEF.md
# Front-Panel Run Control Synchronizer

This block turns an operator's console request into a clean RUN enable for a processor. The console has four requests: start, continue, read and store. It accepts a request only when it is idle. An accepted request first waits out a fixed one-shot interval that is counted in system clock cycles. At the trailing end of that interval the block raises a start strobe. The strobe stays pending until the free-running run clock is sampled high. A synchronizing flip-flop then captures it, and one cycle later the RUN flip-flop sets.

Once RUN is set, the processor runs in one of two ways, fixed by the request that started it. A start request lets it run continuously until a halt indication arrives. A continue, read or store request lets it run for a single cycle, and the first cycle-done indication ends the run. Halt ends a run in either mode.

The run clock is treated as a level that is sampled by the system clock. All state is synchronous to the system clock. A strobe can never be lost, however briefly the run clock is high.

Top module: `run_ctl_sync`

## Requirements
- R1: After reset, and after any reset that interrupts a request, `run` is 0 and stays 0 until a new request is accepted.
- R2: A request is accepted at system clock edge T when the block is idle. The one-shot then lasts ONESHOT_CYC cycles. Let E be the first edge with E >= T+ONESHOT_CYC+1 at which `run_clk` is sampled 1. With the default level qualification, `run` becomes 1 just after edge E+1, so the latency is E+1-T edges.
- R3: The pending strobe is held until it is captured, so RUN still sets with the R2 latency when `run_clk` is high for only one system cycle per period.
- R4: A run started by continue, read or store is single-cycle mode. `run` stays 1 until `cyc_done` is sampled 1 and clears just after that edge.
- R5: A run started by start is continuous mode. `cyc_done` has no effect on it, and `run` stays 1.
- R6: `halt` sampled 1 while `run` is 1 clears `run` just after that edge, in either mode.
- R7: A request that arrives while the one-shot is timing, a strobe is pending or captured, or `run` is 1 is ignored. It does not restart the timing, it does not change the mode, and it produces no second run.
- R8: When start is requested in the same cycle as any other request, start takes priority and the run is continuous.
- R9: With no request, `run_clk`, `cyc_done` and `halt` leave `run` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_clk | input | 1 | Free-running run clock, sampled as a level |
| req_start | input | 1 | Console start request (continuous run) |
| req_cont | input | 1 | Console continue request (single cycle) |
| req_read | input | 1 | Console read request (single cycle) |
| req_store | input | 1 | Console store request (single cycle) |
| cyc_done | input | 1 | CPU indicates a cycle has completed |
| halt | input | 1 | CPU halt indication; ends any run |
| run | output | 1 | RUN enable to the processor |

## Verification
The assertions check on every cycle that the four phases (one-shot, pending strobe, captured strobe, RUN) are never active together. They also check that RUN rises only from a captured strobe, that a capture needs a pending strobe and a qualified run clock, that a new one-shot starts only from idle, and how halt and cycle-done clear RUN in each mode. Only the bench's scenarios can show the exact latency from a request to RUN across run-clock periods, duty cycles and phases. The same holds for the interval of the one-shot itself, the priority among simultaneous requests, and the absence of a second run after requests that were ignored or cut off by reset.

// File: rtl/run_ctl_pkg.sv
package run_ctl_pkg;

   typedef enum logic {
      MODE_STEP = 1'b0,
      MODE_FREE = 1'b1
   } run_mode_e;

   typedef enum logic {
      CAP_LEVEL = 1'b0,
      CAP_RISE  = 1'b1
   } cap_kind_e;

   // start outranks every single-cycle request
   function automatic run_mode_e pick_mode(input logic start_req);
      return start_req ? MODE_FREE : MODE_STEP;
   endfunction

endpackage

// File: rtl/run_ctl_oneshot.sv
module run_ctl_oneshot #(
   parameter int ONESHOT_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active,
   output logic expire
);
   localparam int CNT_W = (ONESHOT_CYC > 2) ? $clog2(ONESHOT_CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ONESHOT_CYC - 1);

   if (ONESHOT_CYC < 2) begin : g_bad_len
      $error("run_ctl_oneshot: ONESHOT_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             act_q;

   // trailing end of the interval: last counted cycle
   assign expire = act_q && (cnt_q == '0);
   assign active = act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (fire && !act_q) begin
         act_q <= 1'b1;
         cnt_q <= LOAD_VAL;
      end else if (expire) begin
         act_q <= 1'b0;
      end else if (act_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/run_ctl_capture.sv
module run_ctl_capture
   import run_ctl_pkg::*;
#(
   parameter cap_kind_e CAPTURE = CAP_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_clk,
   input  logic strobe,
   output logic pend,
   output logic sync_q,
   output logic qual
);
   if (CAPTURE == CAP_RISE) begin : g_rise
      logic rc_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rc_q <= 1'b0;
         else        rc_q <= run_clk;
      end
      assign qual = run_clk && !rc_q;
   end else begin : g_level
      assign qual = run_clk;
   end

   logic pend_q;
   logic sy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         sy_q   <= 1'b0;
      end else begin
         if (strobe)
            pend_q <= 1'b1;
         else if (pend_q && qual)
            pend_q <= 1'b0;
         // sync stage is a single-cycle pulse handing off to RUN
         sy_q <= pend_q && qual && !sy_q;
      end
   end

   assign pend   = pend_q;
   assign sync_q = sy_q;
endmodule

// File: rtl/run_ctl_runff.sv
module run_ctl_runff
   import run_ctl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mode_load,
   input  run_mode_e mode_in,
   input  logic      set_run,
   input  logic      cyc_done,
   input  logic      halt,
   output logic      run,
   output logic      mode_free
);
   run_mode_e mode_q;
   logic      run_q;
   logic      clr;

   assign clr = run_q && (halt || ((mode_q == MODE_STEP) && cyc_done));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_STEP;
         run_q  <= 1'b0;
      end else begin
         if (mode_load)
            mode_q <= mode_in;
         if (set_run)
            run_q <= 1'b1;
         else if (clr)
            run_q <= 1'b0;
      end
   end

   assign run       = run_q;
   assign mode_free = (mode_q == MODE_FREE);
endmodule

// File: rtl/run_ctl_sync.sv
module run_ctl_sync
   import run_ctl_pkg::*;
#(
   parameter int        ONESHOT_CYC = 500,
   parameter cap_kind_e CAPTURE     = CAP_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_clk,
   input  logic req_start,
   input  logic req_cont,
   input  logic req_read,
   input  logic req_store,
   input  logic cyc_done,
   input  logic halt,
   output logic run
);
   logic any_req;
   logic idle;
   logic accept;
   logic os_active;
   logic os_expire;
   logic pend;
   logic sync_q;
   logic rclk_qual;
   logic mode_free;

   assign any_req = req_start || req_cont || req_read || req_store;
   assign idle    = !os_active && !pend && !sync_q && !run;
   assign accept  = any_req && idle;

   run_ctl_oneshot #(.ONESHOT_CYC(ONESHOT_CYC)) u_os (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (accept),
      .active (os_active),
      .expire (os_expire)
   );

   run_ctl_capture #(.CAPTURE(CAPTURE)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_clk (run_clk),
      .strobe  (os_expire),
      .pend    (pend),
      .sync_q  (sync_q),
      .qual    (rclk_qual)
   );

   run_ctl_runff u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_load (accept),
      .mode_in   (pick_mode(req_start)),
      .set_run   (sync_q),
      .cyc_done  (cyc_done),
      .halt      (halt),
      .run       (run),
      .mode_free (mode_free)
   );
endmodule

// File: rtl/run_ctl_sync_chk.sv
module run_ctl_sync_chk (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic sync_q,
   input logic pend,
   input logic os_active,
   input logic rclk_qual,
   input logic mode_free,
   input logic cyc_done,
   input logic halt
);
   AST_RUN_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(sync_q)); // R2
   AST_SYNC_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_q) |-> $past(pend && rclk_qual)); // R3
   AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !mode_free && cyc_done) |=> !run); // R4
   AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_free && !halt) |=> run); // R5
   AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (run && halt) |=> !run); // R6
   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(os_active) |-> $past(!run && !pend && !sync_q)); // R7
   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({os_active, pend, sync_q, run})); // R7
endmodule

bind run_ctl_sync run_ctl_sync_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .sync_q    (sync_q),
   .pend      (pend),
   .os_active (os_active),
   .rclk_qual (rclk_qual),
   .mode_free (mode_free),
   .cyc_done  (cyc_done),
   .halt      (halt)
);

// File: tb/run_ctl_sync_test.sv
module run_ctl_sync_test;
   localparam int LEN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_clk = 1'b0;
   logic req_start = 1'b0, req_cont = 1'b0, req_read = 1'b0, req_store = 1'b0;
   logic cyc_done = 1'b0, halt = 1'b0;
   logic run;

   int tests = 0;
   int fails = 0;
   int edge_cnt = 0;
   int per = 4, hi = 1, ph = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   run_ctl_sync #(.ONESHOT_CYC(LEN)) uut (
      .clk(clk), .rst_n(rst_n), .run_clk(run_clk),
      .req_start(req_start), .req_cont(req_cont),
      .req_read(req_read), .req_store(req_store),
      .cyc_done(cyc_done), .halt(halt), .run(run)
   );

   function automatic bit rc(int k);
      return ((k + ph) % per) < hi;
   endfunction

   always @(posedge clk) edge_cnt <= edge_cnt + 1;
   always @(negedge clk) run_clk <= rc(edge_cnt + 1);

   function automatic int exp_lat(int t);
      for (int k = t + LEN + 1; k < t + LEN + 200; k++)
         if (rc(k)) return k + 1 - t;
      return -1;
   endfunction

   task automatic check(string tag, int act, int expv);
      tests++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // issue requests for one edge; returns the edge index of acceptance
   task automatic request(input bit s, input bit c, input bit r, input bit st, output int t);
      req_start = s; req_cont = c; req_read = r; req_store = st;
      t = edge_cnt + 1;
      tick();
      req_start = 0; req_cont = 0; req_read = 0; req_store = 0;
   endtask

   task automatic wait_run(input int t, output int lat);
      int n = 0;
      while (!run && n < 400) begin tick(); n++; end
      lat = edge_cnt - t;
   endtask

   task automatic pulse_done(); cyc_done = 1; tick(); cyc_done = 0; endtask
   task automatic pulse_halt(); halt = 1; tick(); halt = 0; endtask

   task automatic stay_low(string tag, int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin tick(); if (run) seen = 1; end
      check(tag, seen, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int t, lat;
      @(negedge clk); tick(); tick();
      check("R1 reset run", run, 0);
      rst_n = 1;
      tick();
      // R9: activity on every other input, no request
      per = 3; hi = 1; ph = 0;
      for (int i = 0; i < 20; i++) begin
         cyc_done = i[0]; halt = i[1];
         tick();
         check("R9 idle run", run, 0);
      end
      cyc_done = 0; halt = 0;

      // sweep over run-clock shapes and request kinds
      for (int pi = 0; pi < 4; pi++) begin
         per = (pi == 0) ? 2 : (pi == 1) ? 3 : (pi == 2) ? 5 : 7;
         for (int h = 1; h < per; h++) begin
            hi = h;
            for (int p = 0; p < per; p++) begin
               int m;
               ph = p;
               m = p % 4;
               tick();
               request(m == 0, m == 1, m == 2, m == 3, t);
               wait_run(t, lat);
               check(h == 1 ? "R3 short clock latency" : "R2 latency", lat, exp_lat(t));
               tick(); tick();
               check("R2 run held", run, 1);
               pulse_done();
               if (m == 0) begin
                  check("R5 cycle done ignored", run, 1);
                  pulse_halt();
                  check("R6 halt free", run, 0);
               end else begin
                  check("R4 single cycle clear", run, 0);
               end
            end
         end
      end

      per = 5; hi = 2; ph = 1;
      // R8: start with read together
      tick();
      request(1, 0, 1, 0, t);
      wait_run(t, lat);
      check("R8 latency", lat, exp_lat(t));
      pulse_done();
      check("R8 start wins", run, 1);
      pulse_halt();
      check("R6 halt after R8", run, 0);

      // R6: halt in single mode
      request(0, 1, 0, 0, t);
      wait_run(t, lat);
      pulse_halt();
      check("R6 halt single", run, 0);

      // R7: start during one-shot neither restarts nor changes mode
      request(0, 0, 1, 0, t);
      tick(); tick();
      req_start = 1; tick(); req_start = 0;
      wait_run(t, lat);
      check("R7 no restart", lat, exp_lat(t));
      req_store = 1; tick(); req_store = 0;
      check("R7 run kept", run, 1);
      pulse_done();
      check("R7 mode unchanged", run, 0);
      stay_low("R7 no second run", LEN + 3 * per + 4);

      // R7: request exactly at the one-shot's last cycle
      request(0, 1, 0, 0, t);
      repeat (LEN - 1) tick();
      req_cont = 1; tick(); req_cont = 0;
      wait_run(t, lat);
      check("R7 late request latency", lat, exp_lat(t));
      pulse_done();
      stay_low("R7 late request dropped", LEN + 3 * per + 4);

      // R1: reset in the middle of the one-shot and while pending
      request(1, 0, 0, 0, t);
      tick(); tick(); tick();
      rst_n = 0; tick(); rst_n = 1;
      stay_low("R1 reset mid one-shot", LEN + 3 * per + 4);
      per = 40; hi = 1; ph = 0;
      request(0, 0, 0, 1, t);
      repeat (LEN + 2) tick();
      rst_n = 0; tick(); rst_n = 1;
      stay_low("R1 reset while pending", 90);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule